// File: doc/BRIEF.md
# Dual-Channel Host Mailbox Interrupt Logic

This block holds the interrupt logic of a two-channel mailbox that sits between an external host bus and a local controller. The host side has a chip select for each channel, one address line and active-low read and write strobes. All of these are asynchronous to the local clock. A host write to a channel stores the data byte in that channel's inbound register and marks it full. While its enable is set, a full register raises an interrupt to the local CPU. The local CPU acknowledges the register to empty it.

In the other direction, the local CPU signals the host through three request latches. The latches sit in a local port data register. A latch can only be raised by a guarded sequence: the CPU first reads the port and sees the bit at 0, then writes a 1 to it. Writing a 0 drops the latch. A host read of a channel's outbound data register also drops its latches as a side effect. One of these reads clears two latches. The latches drive the host request outputs only while slave mode is enabled.

Top module: `host_mbox_irq`

## Requirements
- R1: A synchronous active-low reset clears both full flags, all three latches, all arm flags, every other port bit, both interrupt enables and the slave enable, so all outputs read 0.
- R2: `irq_ibf1` equals channel-1 full AND interrupt enable 1, and `irq_ibf2` equals channel-2 full AND interrupt enable 2, with no added register delay. A write on `loc_ctl_we` loads the control register: bit 0 is the slave enable, bit 1 is interrupt enable 1, bit 2 is interrupt enable 2.
- R3: A host write is a falling edge of `host_wr_n` with a channel's chip select low, after a SYNC_STAGES-flop synchroniser. It copies `host_wdata` into that channel's register and sets its full flag at clock edge n, where the strobe was first sampled low at edge n-SYNC_STAGES. `host_a0` has no effect on writes.
- R4: `loc_idr_ack[c]` clears channel c's full flag at the next edge. A host write taking effect on the same edge wins, and the flag stays set.
- R5: `loc_port_rdata` returns the port register. Bits 3, 4 and 5 are the latches for `hirq11`, `hirq1` and `hirq12`. Every other bit holds the value last written through `loc_port_wdata`.
- R6: `hirq11`, `hirq1` and `hirq12` are their latches ANDed with the slave enable. No latch can be set while the slave enable is 0.
- R7: A `loc_port_rd` cycle arms every latch bit that reads 0. The next `loc_port_we` sets each armed latch bit written with 1.
- R8: Any `loc_port_we` clears all arm flags. Writing 1 to a latch bit that is not armed leaves that latch unchanged.
- R9: Writing 0 to a latch bit clears that latch at the next edge, whether or not it is armed.
- R10: A synchronised falling edge of `host_rd_n` with `host_cs1_n` low and `host_a0` low clears the `hirq1` and `hirq12` latches. The same read with `host_a0` high clears nothing.
- R11: A synchronised falling edge of `host_rd_n` with `host_cs2_n` low and `host_a0` low clears the `hirq11` latch and leaves the other two unchanged.
- R12: A host-read clear and a local set on the same edge leave the latch at 0.
- R13: When `loc_port_rd` and `loc_port_we` are high in the same cycle, the write acts on the arm flags held before that cycle, and the read arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs1_n | input | 1 | Host chip select, channel 1, active low |
| host_cs2_n | input | 1 | Host chip select, channel 2, active low |
| host_a0 | input | 1 | Host address bit 0 |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | DATA_W | Host write data |
| loc_ctl_we | input | 1 | Local control register write |
| loc_ctl_wdata | input | 3 | Control data: slave enable, IBF1 enable, IBF2 enable |
| loc_idr_ack | input | 2 | Local acknowledge of each inbound register |
| loc_port_rd | input | 1 | Local read of the port register |
| loc_port_we | input | 1 | Local write of the port register |
| loc_port_wdata | input | PORT_W | Port register write data |
| loc_port_rdata | output | PORT_W | Port register read data |
| idr1_q | output | DATA_W | Channel-1 inbound data |
| idr2_q | output | DATA_W | Channel-2 inbound data |
| idr_full | output | 2 | Full flag of each channel |
| irq_ibf1 | output | 1 | Channel-1 input-full interrupt |
| irq_ibf2 | output | 1 | Channel-2 input-full interrupt |
| hirq11 | output | 1 | Host request from port bit 3 |
| hirq1 | output | 1 | Host request from port bit 4 |
| hirq12 | output | 1 | Host request from port bit 5 |

## Verification
The bench builds the block with DATA_W=8, PORT_W=8 and SYNC_STAGES=2, which places the latch field at bits 3 to 5 of an 8-bit port. Plain bits on both sides of the latch field make any leak between latch bits and their neighbours show up at the read port. The short two-flop synchroniser makes the edge on which a host strobe acts predictable from the bench. Directed steps use this to line a host write up with an acknowledge, and a host read clear with a local set, on the same edge. These are the priority cases R4 and R12, and a long random phase covers the rest.

// File: rtl/hmb_pkg.sv
// Shared constants and types for the host mailbox interrupt block.
// Assumes two mailbox channels and three host request latches.
package hmb_pkg;

    localparam int NUM_CH  = 2;
    localparam int NUM_LAT = 3;

    // latch index order inside the latch field (lowest port bit first)
    localparam int LAT_HIRQ11 = 0;
    localparam int LAT_HIRQ1  = 1;
    localparam int LAT_HIRQ12 = 2;

    localparam int CTL_W = 3;

    // local control register: bit 0 slave enable, bits 2:1 IBF enables
    typedef struct packed {
        logic [NUM_CH-1:0] ibfie;
        logic              hie;
    } ctl_t;

endpackage

// File: rtl/hmb_host_front.sv
// Host bus front end: brings the asynchronous host strobes, chip selects
// and address bit into the local clock domain and turns falling strobe
// edges into single-cycle write and outbound-read events per channel.
// Assumes select and address settle before the strobe falls.
module hmb_host_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs1_n,
    input  logic       cs2_n,
    input  logic       a0,
    input  logic       rd_n,
    input  logic       wr_n,
    output logic [1:0] wr_evt,
    output logic [1:0] odr_rd
);

    localparam int         W    = 5;
    localparam logic [W-1:0] IDLE = 5'b01111; // {a0, cs2_n, cs1_n, wr_n, rd_n}

    logic [W-1:0] raw;
    logic [W-1:0] stage_q [SYNC_STAGES];
    logic [W-1:0] lvl;
    logic         rd_prev_q;
    logic         wr_prev_q;
    logic         rd_fall;
    logic         wr_fall;
    logic [1:0]   sel;

    assign raw = {a0, cs2_n, cs1_n, wr_n, rd_n};

    // synchroniser chain for all host control inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) stage_q[k] <= IDLE;
        end else begin
            stage_q[0] <= raw;
            for (int k = 1; k < SYNC_STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign lvl = stage_q[SYNC_STAGES-1];

    // previous strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev_q <= 1'b1;
            wr_prev_q <= 1'b1;
        end else begin
            rd_prev_q <= lvl[0];
            wr_prev_q <= lvl[1];
        end
    end

    // event decode: falling strobe qualified by channel select and address
    always_comb begin
        rd_fall = rd_prev_q & ~lvl[0];
        wr_fall = wr_prev_q & ~lvl[1];
        sel     = {~lvl[3], ~lvl[2]};
        wr_evt  = {2{wr_fall}} & sel;
        odr_rd  = {2{rd_fall & ~lvl[4]}} & sel;
    end

endmodule

// File: rtl/hmb_ibf_chan.sv
// One inbound mailbox channel: data register, full flag and the gated
// input-full interrupt. A host write event outranks a local acknowledge.
module hmb_ibf_chan #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_evt_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ack_i,
    input  logic              ie_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o,
    output logic              irq_o
);

    logic              full_q;
    logic [DATA_W-1:0] data_q;

    // full flag and data capture; a fresh write keeps the flag set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (ack_i) full_q <= 1'b0;
            if (wr_evt_i) begin
                full_q <= 1'b1;
                data_q <= wdata_i;
            end
        end
    end

    // interrupt follows the flag without a register stage
    assign irq_o  = full_q & ie_i;
    assign full_o = full_q;
    assign data_o = data_q;

endmodule

// File: rtl/hmb_irq_latch.sv
// Local port data register with embedded host request latches.
// Latch bits need a read-0 then write-1 sequence to set; writing 0 or a
// host outbound read clears them, and the host clear wins. Bits outside
// the latch field are plain storage.
module hmb_irq_latch #(
    parameter int PORT_W   = 8,
    parameter int LAT_BASE = 3,
    parameter int NUM_LAT  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hie_i,
    input  logic               port_rd_i,
    input  logic               port_we_i,
    input  logic [PORT_W-1:0]  port_wdata_i,
    input  logic [NUM_LAT-1:0] host_clr_i,
    output logic [PORT_W-1:0]  port_rdata_o,
    output logic [NUM_LAT-1:0] lat_o,
    output logic [NUM_LAT-1:0] armed_o
);

    localparam int LAT_TOP = LAT_BASE + NUM_LAT;

    logic [PORT_W-1:0]  port_q;
    logic [NUM_LAT-1:0] armed_q;

    // port bits: plain storage or guarded request latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            for (int b = 0; b < PORT_W; b++) begin
                if (b >= LAT_BASE && b < LAT_TOP) begin
                    if (port_we_i) begin
                        if (!port_wdata_i[b])
                            port_q[b] <= 1'b0;
                        else if (armed_q[b-LAT_BASE] && hie_i)
                            port_q[b] <= 1'b1;
                    end
                    if (host_clr_i[b-LAT_BASE]) port_q[b] <= 1'b0;
                end else if (port_we_i) begin
                    port_q[b] <= port_wdata_i[b];
                end
            end
        end
    end

    // arm flags: a read that sees 0 arms, any write consumes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= '0;
        end else if (port_we_i) begin
            armed_q <= '0;
        end else if (port_rd_i) begin
            armed_q <= ~port_q[LAT_BASE +: NUM_LAT];
        end
    end

    assign port_rdata_o = port_q;
    assign lat_o        = port_q[LAT_BASE +: NUM_LAT];
    assign armed_o      = armed_q;

endmodule

// File: rtl/host_mbox_irq.sv
// Top of the dual-channel host mailbox interrupt logic. Holds the local
// control register, instantiates the host front end, one inbound channel
// per mailbox and the port register with its request latches, and gates
// the host request outputs with slave mode.
module host_mbox_irq
    import hmb_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PORT_W      = 8,
    parameter int LAT_BASE    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs1_n,
    input  logic              host_cs2_n,
    input  logic              host_a0,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              loc_ctl_we,
    input  logic [CTL_W-1:0]  loc_ctl_wdata,
    input  logic [1:0]        loc_idr_ack,
    input  logic              loc_port_rd,
    input  logic              loc_port_we,
    input  logic [PORT_W-1:0] loc_port_wdata,
    output logic [PORT_W-1:0] loc_port_rdata,
    output logic [DATA_W-1:0] idr1_q,
    output logic [DATA_W-1:0] idr2_q,
    output logic [1:0]        idr_full,
    output logic              irq_ibf1,
    output logic              irq_ibf2,
    output logic              hirq11,
    output logic              hirq1,
    output logic              hirq12
);

    ctl_t               ctl_q;
    logic [1:0]         wr_evt;
    logic [1:0]         odr_rd;
    logic [DATA_W-1:0]  idr_data [NUM_CH];
    logic [NUM_CH-1:0]  ibf_irq;
    logic [NUM_LAT-1:0] lat_clr;
    logic [NUM_LAT-1:0] lat;
    logic [NUM_LAT-1:0] armed;

    // local control register: slave enable and interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n)         ctl_q <= '0;
        else if (loc_ctl_we) ctl_q <= ctl_t'(loc_ctl_wdata);
    end

    hmb_host_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs1_n  (host_cs1_n),
        .cs2_n  (host_cs2_n),
        .a0     (host_a0),
        .rd_n   (host_rd_n),
        .wr_n   (host_wr_n),
        .wr_evt (wr_evt),
        .odr_rd (odr_rd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        hmb_ibf_chan #(.DATA_W(DATA_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_evt_i (wr_evt[c]),
            .wdata_i  (host_wdata),
            .ack_i    (loc_idr_ack[c]),
            .ie_i     (ctl_q.ibfie[c]),
            .full_o   (idr_full[c]),
            .data_o   (idr_data[c]),
            .irq_o    (ibf_irq[c])
        );
    end

    // outbound read of channel 1 clears two latches, channel 2 one
    always_comb begin
        lat_clr             = '0;
        lat_clr[LAT_HIRQ11] = odr_rd[1];
        lat_clr[LAT_HIRQ1]  = odr_rd[0];
        lat_clr[LAT_HIRQ12] = odr_rd[0];
    end

    hmb_irq_latch #(
        .PORT_W   (PORT_W),
        .LAT_BASE (LAT_BASE),
        .NUM_LAT  (NUM_LAT)
    ) u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .hie_i        (ctl_q.hie),
        .port_rd_i    (loc_port_rd),
        .port_we_i    (loc_port_we),
        .port_wdata_i (loc_port_wdata),
        .host_clr_i   (lat_clr),
        .port_rdata_o (loc_port_rdata),
        .lat_o        (lat),
        .armed_o      (armed)
    );

    // output mapping with slave-mode gating of the host requests
    assign idr1_q   = idr_data[0];
    assign idr2_q   = idr_data[1];
    assign irq_ibf1 = ibf_irq[0];
    assign irq_ibf2 = ibf_irq[1];
    assign hirq11   = lat[LAT_HIRQ11] & ctl_q.hie;
    assign hirq1    = lat[LAT_HIRQ1]  & ctl_q.hie;
    assign hirq12   = lat[LAT_HIRQ12] & ctl_q.hie;

endmodule

// File: rtl/hmb_checker.sv
// Property checker for host_mbox_irq, attached with bind.
module hmb_checker #(
    parameter int PORT_W   = 8,
    parameter int LAT_BASE = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        wr_evt,
    input logic [1:0]        odr_rd,
    input logic [1:0]        ack,
    input logic [1:0]        full,
    input logic [2:0]        lat,
    input logic [2:0]        armed,
    input logic              hie,
    input logic              port_we,
    input logic [PORT_W-1:0] port_wdata
);

    // R1: state is clear on the first cycle after reset release
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (full == 2'b00 && lat == 3'b000 && armed == 3'b000 && !hie));

    // R3: a host write event leaves its channel full
    p_full_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt != 2'b00) |=> ((full & $past(wr_evt)) == $past(wr_evt)));

    // R4: acknowledge without a competing write empties the channel
    p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[0] && !wr_evt[0]) |=> !full[0]);

    // R4: same for channel 2
    p_ack_clear2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[1] && !wr_evt[1]) |=> !full[1]);

    // R6: no latch rises while slave mode is off
    p_slave_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !hie |=> ((lat & ~$past(lat)) == 3'b000));

    // R8: a rising latch bit must have been armed and written
    p_arm_needed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat & ~$past(lat)) != 3'b000) |->
            ($past(port_we) && (($past(armed) & lat & ~$past(lat)) == (lat & ~$past(lat)))));

    // R9: bits written with 0 are clear afterwards
    p_wr0_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        port_we |=> ((lat & ~$past(port_wdata[LAT_BASE +: 3])) == 3'b000));

    // R10: outbound read of channel 1 clears the upper two latches
    p_odr1_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        odr_rd[0] |=> (!lat[1] && !lat[2]));

    // R11: outbound read of channel 2 clears the lowest latch
    p_odr2_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        odr_rd[1] |=> !lat[0]);

endmodule

bind host_mbox_irq hmb_checker #(
    .PORT_W   (PORT_W),
    .LAT_BASE (LAT_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_evt     (wr_evt),
    .odr_rd     (odr_rd),
    .ack        (loc_idr_ack),
    .full       (idr_full),
    .lat        (lat),
    .armed      (armed),
    .hie        (ctl_q.hie),
    .port_we    (loc_port_we),
    .port_wdata (loc_port_wdata)
);

// File: tb/host_mbox_irq_test.sv
module host_mbox_irq_test;

    localparam int DW   = 8;
    localparam int PW   = 8;
    localparam int LB   = 3;
    localparam int SYNC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs1_n = 1'b1, cs2_n = 1'b1, a0 = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [DW-1:0] hwdata = '0;
    logic          ctl_we = 1'b0;
    logic [2:0]    ctl_wd = '0;
    logic [1:0]    ack = '0;
    logic          prd = 1'b0, pwe = 1'b0;
    logic [PW-1:0] pwd = '0;
    logic [PW-1:0] prdata;
    logic [DW-1:0] idr1, idr2;
    logic [1:0]    full;
    logic          ibf1, ibf2, h11, h1, h12;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    host_mbox_irq #(.DATA_W(DW), .PORT_W(PW), .LAT_BASE(LB), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n),
        .host_cs1_n(cs1_n), .host_cs2_n(cs2_n), .host_a0(a0),
        .host_rd_n(rd_n), .host_wr_n(wr_n), .host_wdata(hwdata),
        .loc_ctl_we(ctl_we), .loc_ctl_wdata(ctl_wd), .loc_idr_ack(ack),
        .loc_port_rd(prd), .loc_port_we(pwe), .loc_port_wdata(pwd),
        .loc_port_rdata(prdata), .idr1_q(idr1), .idr2_q(idr2), .idr_full(full),
        .irq_ibf1(ibf1), .irq_ibf2(ibf2), .hirq11(h11), .hirq1(h1), .hirq12(h12)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          mvalid = 0;
    bit          m_hie;
    bit [1:0]    m_ie, m_full;
    bit [DW-1:0] m_idr [2];
    bit [PW-1:0] m_port;
    bit [2:0]    m_arm;
    bit          h_rd [SYNC+1], h_wr [SYNC+1], h_c1 [SYNC+1], h_c2 [SYNC+1], h_a0 [SYNC+1];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hie = 0; m_ie = 0; m_full = 0; m_port = 0; m_arm = 0;
            m_idr[0] = 0; m_idr[1] = 0;
            for (int k = 0; k <= SYNC; k++) begin
                h_rd[k] = 1; h_wr[k] = 1; h_c1[k] = 1; h_c2[k] = 1; h_a0[k] = 0;
            end
            mvalid = 1;
        end else begin
            bit rdf, wrf, s1, s2, sa;
            bit [PW-1:0] np;
            bit [2:0] na;
            bit [1:0] nf;
            rdf = h_rd[SYNC] && !h_rd[SYNC-1];
            wrf = h_wr[SYNC] && !h_wr[SYNC-1];
            s1 = !h_c1[SYNC-1]; s2 = !h_c2[SYNC-1]; sa = h_a0[SYNC-1];
            np = m_port; na = m_arm; nf = m_full;
            if (pwe) begin
                for (int b = 0; b < PW; b++) begin
                    if (b >= LB && b < LB + 3) begin
                        if (!pwd[b]) np[b] = 0;
                        else if (m_arm[b-LB] && m_hie) np[b] = 1;
                    end else np[b] = pwd[b];
                end
                na = 0;
            end else if (prd) begin
                na = ~m_port[LB +: 3];
            end
            if (rdf && s1 && !sa) begin np[LB+1] = 0; np[LB+2] = 0; end
            if (rdf && s2 && !sa) np[LB] = 0;
            for (int c = 0; c < 2; c++) begin
                if (ack[c]) nf[c] = 0;
                if (wrf && ((c == 0) ? s1 : s2)) begin nf[c] = 1; m_idr[c] = hwdata; end
            end
            if (ctl_we) begin m_hie = ctl_wd[0]; m_ie = ctl_wd[2:1]; end
            m_port = np; m_arm = na; m_full = nf;
            for (int k = SYNC; k >= 1; k--) begin
                h_rd[k] = h_rd[k-1]; h_wr[k] = h_wr[k-1]; h_c1[k] = h_c1[k-1];
                h_c2[k] = h_c2[k-1]; h_a0[k] = h_a0[k-1];
            end
            h_rd[0] = rd_n; h_wr[0] = wr_n; h_c1[0] = cs1_n; h_c2[0] = cs2_n; h_a0[0] = a0;
        end
    end

    // compare outputs with the model on every clock, away from the edge
    always @(negedge clk) begin
        if (mvalid && !finished) begin
            chk("R2 irq_ibf1", ibf1, m_full[0] & m_ie[0]);
            chk("R2 irq_ibf2", ibf2, m_full[1] & m_ie[1]);
            chk("R3 idr_full", full, m_full);
            chk("R3 idr1", idr1, m_idr[0]);
            chk("R3 idr2", idr2, m_idr[1]);
            chk("R5 port_rdata", prdata, m_port);
            chk("R6 hirq", {h12, h1, h11}, m_port[LB +: 3] & {3{m_hie}});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_op(input bit wr, input int ch, input bit adr, input logic [DW-1:0] d);
        @(negedge clk);
        cs1_n = (ch != 1); cs2_n = (ch != 2); a0 = adr; hwdata = d;
        @(negedge clk);
        if (wr) wr_n = 0; else rd_n = 0;
        cyc(4);
        wr_n = 1; rd_n = 1;
        cyc(4);
        cs1_n = 1; cs2_n = 1; a0 = 0;
        cyc(1);
    endtask

    task automatic ctl_write(input logic [2:0] v);
        @(negedge clk); ctl_we = 1; ctl_wd = v;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic port_read();
        @(negedge clk); prd = 1;
        @(negedge clk); prd = 0;
    endtask

    task automatic port_write(input logic [PW-1:0] v);
        @(negedge clk); pwe = 1; pwd = v;
        @(negedge clk); pwe = 0;
    endtask

    // watchdog
    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst_n = 1;
        cyc(1);
        // R1: everything clear after reset
        chk("R1 full", full, 2'b00);
        chk("R1 rdata", prdata, 8'h00);
        chk("R1 hirq", {h12, h1, h11}, 3'b000);
        chk("R1 ibf", {ibf2, ibf1}, 2'b00);

        // R2/R3: slave on, IBF1 enabled, IBF2 disabled
        ctl_write(3'b011);
        host_op(1, 1, 0, 8'hA5);
        chk("R3 idr1 data", idr1, 8'hA5);
        chk("R2 ibf1 on", ibf1, 1'b1);
        host_op(1, 2, 1, 8'h3C);        // address bit ignored on writes
        chk("R3 full ch2 with a0=1", full[1], 1'b1);
        chk("R2 ibf2 masked", ibf2, 1'b0);
        ctl_write(3'b111);
        chk("R2 ibf2 enabled", ibf2, 1'b1);

        // R4: acknowledge empties channel 1
        @(negedge clk); ack = 2'b01;
        @(negedge clk); ack = 2'b00;
        chk("R4 ack clears", full[0], 1'b0);

        // R4: ack on the same edge as a host write -> write wins
        @(negedge clk); cs1_n = 0; hwdata = 8'h5A;
        @(negedge clk); wr_n = 0;              // sampled low at edge e0
        @(negedge clk);
        @(negedge clk); ack = 2'b01;           // edge e0+SYNC acts
        @(negedge clk); ack = 2'b00;
        chk("R4 write wins over ack", full[0], 1'b1);
        chk("R4 data on collision", idr1, 8'h5A);
        wr_n = 1; cyc(4); cs1_n = 1; cyc(1);

        // R5/R8: write ones without arming: latches stay, plain bits stored
        port_write(8'hFF);
        chk("R8 unarmed write", prdata, 8'hC7);
        chk("R5 plain bits", prdata & 8'hC7, 8'hC7);

        // R7: read 0 then write 1 on bits 3,4 only
        port_read();
        port_write(8'h18);
        chk("R7 set 11 and 1", {h12, h1, h11}, 3'b011);
        chk("R5 latch positions", prdata, 8'h18);
        // R8: arms consumed by the previous write
        port_write(8'h38);
        chk("R8 arm consumed", h12, 1'b0);

        // R13: simultaneous read and write arms nothing
        @(negedge clk); prd = 1; pwe = 1; pwd = 8'h38;
        @(negedge clk); prd = 0; pwe = 0;
        port_write(8'h38);
        chk("R13 rd+we no arm", h12, 1'b0);
        port_read();
        port_write(8'h38);
        chk("R7 set 12", {h12, h1, h11}, 3'b111);

        // R10: status read of channel 1 clears nothing
        host_op(0, 1, 1, 8'h00);
        chk("R10 a0 high no clear", {h12, h1, h11}, 3'b111);
        host_op(0, 1, 0, 8'h00);
        chk("R10 odr1 clears 1 and 12", {h12, h1, h11}, 3'b001);
        // R11
        host_op(0, 2, 0, 8'h00);
        chk("R11 odr2 clears 11", {h12, h1, h11}, 3'b000);

        // R9: write 0 clears without arming
        port_read();
        port_write(8'h38);
        chk("R9 pre-set", {h12, h1, h11}, 3'b111);
        port_write(8'h28);
        chk("R9 write 0 clears", {h12, h1, h11}, 3'b101);

        // R12: host clear and local set on the same edge
        port_read();                           // arms bit 4 (HIRQ1)
        @(negedge clk); cs1_n = 0; a0 = 0;
        @(negedge clk); rd_n = 0;
        @(negedge clk);
        @(negedge clk); pwe = 1; pwd = 8'h38;
        @(negedge clk); pwe = 0;
        chk("R12 host clear wins", h1, 1'b0);
        rd_n = 1; cyc(4); cs1_n = 1; cyc(1);

        // R6: slave mode off gates outputs and blocks setting
        port_read();
        port_write(8'h38);
        chk("R6 set before gate", {h12, h1, h11}, 3'b111);
        port_write(8'h08);
        ctl_write(3'b110);
        chk("R6 outputs gated", {h12, h1, h11}, 3'b000);
        port_read();
        port_write(8'h38);
        chk("R6 no set in non-slave", prdata[5:3], 3'b001);
        ctl_write(3'b111);
        chk("R6 regate", {h12, h1, h11}, 3'b001);

        // random phase, model compared every clock
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            cs1_n  = ($urandom % 3) != 0;
            cs2_n  = ($urandom % 3) != 0;
            a0     = ($urandom % 4) == 0;
            rd_n   = ($urandom % 4) != 0;
            wr_n   = ($urandom % 4) != 0;
            hwdata = DW'($urandom);
            ctl_we = ($urandom % 40) == 0;
            ctl_wd = (($urandom % 5) == 0) ? 3'($urandom) : 3'b111;
            ack    = 2'($urandom) & {1'(($urandom % 4) == 0), 1'(($urandom % 4) == 0)};
            prd    = ($urandom % 4) == 0;
            pwe    = ($urandom % 4) == 0;
            pwd    = PW'($urandom);
        end
        @(negedge clk);
        cs1_n = 1; cs2_n = 1; rd_n = 1; wr_n = 1; ctl_we = 0; ack = 0; prd = 0; pwe = 0;
        cyc(6);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule